// File: doc/BRIEF.md
# Pipelined GF(2) Inner-Product Tree

This block forms the inner product of two equal-length bit vectors over the two-element field. Each element product is a logical AND. The sum of the products is their parity, an XOR reduction. One operand pair is presented together with a valid strobe. A fixed number of clock edges later, the block returns a single result bit with its own valid strobe. Operand pairs may arrive on every clock, back to back, and each pair yields its own result.

The reduction is split into small fixed-size pieces so that no stage holds a long XOR chain. The first registered stage is a row of leaf units. Each leaf ANDs three bit pairs and XORs the three products. Above the leaves, a registered tree of nodes each XORs up to six bits. The tree repeats until one bit remains. With the default 96-bit operands, the stages are 32 leaves, then 6 nodes, then 1 root, which gives three register stages. The operand length, the pairs per leaf and the fan-in per node are parameters. The depth of the tree and the latency follow from them.

Top module: `gf2_dot_tree`

## Requirements
- R1: For every pair accepted with `in_valid` high, `out_bit` equals the XOR over all i of (`vec_a[i]` AND `vec_b[i]`).
- R2: With the default parameters the latency is three register stages. Inputs are sampled on rising edge n, and the matching `out_valid` and `out_bit` are visible from just after rising edge n+2 until edge n+3.
- R3: `out_valid` is high for exactly one cycle for each accepted pair. It stays low for every cycle whose input had `in_valid` low, whatever the operand data was in that cycle.
- R4: A new pair is accepted on every clock. A run of consecutive valid pairs produces the same run of consecutive valid results, in input order, and each result belongs to its own pair.
- R5: Reset is synchronous and active low (`rst_n` = 0). It clears every pipeline stage, so `out_valid` is low in the cycle after a reset edge. Pairs in flight when reset is applied produce no result.
- R6: The corner values give these results. If either operand is all zeros, the result is 0. If both operands are all ones, the result is the parity of the vector length, which is 0 for 96. If both operands contain only bit i set, the result is 1, for i = 0, 47 and 95.
- R7: Bit i of `vec_a` is paired only with bit i of `vec_b`. A set bit in one operand at a position where the other operand is 0 adds nothing to the result. For example, `vec_a` with only bit 5 set and `vec_b` with only bit 6 set gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `vec_a`/`vec_b` as a pair to process this cycle |
| vec_a | input | VEC_W (96) | First operand vector |
| vec_b | input | VEC_W (96) | Second operand vector |
| out_valid | output | 1 | High for one cycle when `out_bit` holds a result |
| out_bit | output | 1 | Inner product modulo 2 of the pair accepted three edges earlier |

## Verification
The bench drives each new pair, or an idle cycle, at a falling edge. The rising edge that follows samples it. The result is due at the third falling edge after the stimulus was driven, just after the third rising edge. The bench holds its expected valid flag and result bit in a three-slot line that shifts once per falling edge. Before shifting, it compares the outputs against the oldest slot. A reset driven at a falling edge empties every slot, so the cycles after a reset must show `out_valid` low, and the pairs that were in flight are never expected to return.

// File: rtl/gf2_dot_pkg.sv
// Package gf2_dot_pkg
// Shared sizing functions for the GF(2) inner-product tree. The leaf row
// and every node level derive their widths from these functions. The
// functions assume a fan-in of at least 2.
package gf2_dot_pkg;

    // Ceiling division, n / d rounded up.
    function automatic int ceil_div(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    // Bit count at a tree level: level 0 is the leaf row, and each higher
    // level divides the count below it by the fan-in, rounded up.
    function automatic int level_w(input int leaves, input int fan, input int lvl);
        int w;
        w = leaves;
        for (int i = 0; i < lvl; i++) begin
            w = ceil_div(w, fan);
        end
        return w;
    endfunction

    // Number of node levels needed to bring the leaf row down to one bit.
    function automatic int node_levels(input int leaves, input int fan);
        int w;
        int n;
        w = leaves;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            if (w > 1) begin
                w = ceil_div(w, fan);
                n++;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/gf2_leaf_stage.sv
// Module gf2_leaf_stage
// First registered stage. The operands are cut into groups of PAIRS bit
// pairs. Each group ANDs its pairs and XORs the products into one leaf
// bit. When VEC_W is not a multiple of PAIRS, the top group is padded
// with zeros, and the padding adds nothing to the parity.
// Assumes PAIRS >= 1. Reset is synchronous and active low.
module gf2_leaf_stage
    import gf2_dot_pkg::*;
#(
    parameter int VEC_W  = 96,
    parameter int PAIRS  = 3,
    localparam int LEAVES = ceil_div(VEC_W, PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  vec_a,
    input  logic [VEC_W-1:0]  vec_b,
    output logic [LEAVES-1:0] leaf_q
);
    localparam int PAD_W = LEAVES * PAIRS;

    logic [PAD_W-1:0]  a_pad;
    logic [PAD_W-1:0]  b_pad;
    logic [LEAVES-1:0] leaf_d;

    // Zero-extend both operands to a whole number of leaf groups.
    always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[VEC_W-1:0] = vec_a;
        b_pad[VEC_W-1:0] = vec_b;
    end

    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        // Each leaf gives the parity of its ANDed bit pairs.
        assign leaf_d[g] = ^(a_pad[g*PAIRS +: PAIRS] & b_pad[g*PAIRS +: PAIRS]);
    end

    // Register the leaf row, which is cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leaf_q <= '0;
        end else begin
            leaf_q <= leaf_d;
        end
    end

endmodule

// File: rtl/gf2_xor_level.sv
// Module gf2_xor_level
// One registered node level of the reduction tree. The input bits are
// grouped in FAN-wide slices, and each node registers the XOR of its slice.
// The last slice is zero-padded, which does not change its parity.
// Assumes IN_N >= 1 and FAN >= 2. Reset is synchronous and active low.
module gf2_xor_level
    import gf2_dot_pkg::*;
#(
    parameter int IN_N  = 32,
    parameter int FAN   = 6,
    localparam int OUT_N = ceil_div(IN_N, FAN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_N-1:0]  in_bits,
    output logic [OUT_N-1:0] out_q
);
    localparam int PAD_N = OUT_N * FAN;

    logic [PAD_N-1:0] in_pad;
    logic [OUT_N-1:0] node_d;

    // Zero-extend the input row to whole node slices.
    always_comb begin
        in_pad = '0;
        in_pad[IN_N-1:0] = in_bits;
    end

    for (genvar n = 0; n < OUT_N; n++) begin : g_node
        // Each node gives the parity of its FAN-wide slice.
        assign node_d[n] = ^in_pad[n*FAN +: FAN];
    end

    // Register the node outputs, which are cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= node_d;
        end
    end

endmodule

// File: rtl/gf2_valid_pipe.sv
// Module gf2_valid_pipe
// Shift line of DEPTH flops that delays the input strobe by the data
// latency of the tree. Each flop is cleared by the synchronous active-low
// reset, so strobes in flight are dropped. Assumes DEPTH >= 1.
module gf2_valid_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);
    logic [DEPTH-1:0] v_q;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic v_in;
        if (k == 0) begin : g_head
            assign v_in = in_valid;
        end else begin : g_tail
            assign v_in = v_q[k-1];
        end

        // Move the strobe one stage on each clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[k] <= 1'b0;
            end else begin
                v_q[k] <= v_in;
            end
        end
    end

    assign out_valid = v_q[DEPTH-1];

endmodule

// File: rtl/gf2_dot_tree.sv
// Module gf2_dot_tree (top)
// Pipelined inner product over GF(2). A registered leaf row is followed by
// registered XOR node levels until one bit remains. The strobe travels
// through a shift line of the same depth. A new pair can be taken on every
// clock. Assumes VEC_W >= 1, LEAF_PAIRS >= 1 and NODE_FAN >= 2. Reset is
// synchronous and active low.
module gf2_dot_tree
    import gf2_dot_pkg::*;
#(
    parameter int VEC_W      = 96,
    parameter int LEAF_PAIRS = 3,
    parameter int NODE_FAN   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic             out_valid,
    output logic             out_bit
);
    localparam int LEAVES = ceil_div(VEC_W, LEAF_PAIRS);
    localparam int NLV    = node_levels(LEAVES, NODE_FAN);
    localparam int LAT    = 1 + NLV;

    logic [LEAVES-1:0] leaf_bits;
    logic              root_bit;

    gf2_leaf_stage #(
        .VEC_W (VEC_W),
        .PAIRS (LEAF_PAIRS)
    ) i_leaf (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_a  (vec_a),
        .vec_b  (vec_b),
        .leaf_q (leaf_bits)
    );

    for (genvar l = 1; l <= NLV; l++) begin : g_lvl
        localparam int IN_N  = level_w(LEAVES, NODE_FAN, l - 1);
        localparam int OUT_N = level_w(LEAVES, NODE_FAN, l);

        logic [IN_N-1:0]  lvl_in;
        logic [OUT_N-1:0] lvl_out;

        if (l == 1) begin : g_first
            assign lvl_in = leaf_bits;
        end else begin : g_next
            assign lvl_in = g_lvl[l-1].lvl_out;
        end

        gf2_xor_level #(
            .IN_N (IN_N),
            .FAN  (NODE_FAN)
        ) i_level (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_bits (lvl_in),
            .out_q   (lvl_out)
        );
    end

    if (NLV == 0) begin : g_root_leaf
        assign root_bit = leaf_bits[0];
    end else begin : g_root_tree
        assign root_bit = g_lvl[NLV].lvl_out[0];
    end

    gf2_valid_pipe #(
        .DEPTH (LAT)
    ) i_vpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (out_valid)
    );

    assign out_bit = root_bit;

endmodule

// File: rtl/gf2_dot_tree_chk.sv
// Module gf2_dot_tree_chk
// Assertion checker for gf2_dot_tree, attached with bind. It keeps its own
// history of the strobe and of a flat reference parity, LAT entries deep,
// and compares the outputs of the top against that history.
module gf2_dot_tree_chk #(
    parameter int VEC_W = 96,
    parameter int LAT   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] vec_a,
    input logic [VEC_W-1:0] vec_b,
    input logic             out_valid,
    input logic             out_bit
);
    logic [LAT-1:0] hv;
    logic [LAT-1:0] hp;

    // Hold a history of the strobes and the flat reference parities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv <= '0;
            hp <= '0;
        end else begin
            for (int k = LAT - 1; k > 0; k--) begin
                hv[k] <= hv[k-1];
                hp[k] <= hp[k-1];
            end
            hv[0] <= in_valid;
            hp[0] <= ^(vec_a & vec_b);
        end
    end

    // R2 R3: out_valid follows the strobe exactly LAT edges later.
    p_valid_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hv[LAT-1]);

    // R1: a valid result equals the parity of the ANDed operands.
    p_result_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bit == hp[LAT-1]));

    // R5: a reset edge leaves out_valid low in the next cycle.
    p_reset_clears_r5: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R4: back-to-back strobes come out as back-to-back results.
    p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hv[LAT-2]) |=> out_valid);

    // R3: the outputs never carry unknown values outside reset.
    p_known_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({out_valid, out_bit}));

endmodule

bind gf2_dot_tree gf2_dot_tree_chk #(
    .VEC_W (VEC_W),
    .LAT   (LAT)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .vec_a     (vec_a),
    .vec_b     (vec_b),
    .out_valid (out_valid),
    .out_bit   (out_bit)
);

// File: tb/test_gf2_dot_tree.sv
// Bench for gf2_dot_tree. It drives inputs at falling edges and keeps the
// expected strobe and result in a three-slot line. Each falling edge first
// compares the outputs with the oldest slot, then shifts the line and
// drives the next stimulus.
module test_gf2_dot_tree;
    localparam int W = 96;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] vec_a = '0;
    logic [W-1:0] vec_b = '0;
    logic         out_valid;
    logic         out_bit;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    bit    sv [3];
    bit    sp [3];
    string st [3];

    gf2_dot_tree i_gf2_dot_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .vec_a     (vec_a),
        .vec_b     (vec_b),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    always #5 clk = ~clk;

    // Reference result: parity of the bitwise AND.
    function automatic bit ref_dot(input logic [W-1:0] a, input logic [W-1:0] b);
        return ^(a & b);
    endfunction

    function automatic logic [W-1:0] one_hot(input int i);
        logic [W-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [W-1:0] rnd_vec();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    // Compare with the oldest slot, shift the line, then drive the next input.
    task automatic step(input bit rv, input bit v, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
        @(negedge clk);
        n_checks++;
        if (out_valid !== sv[2]) begin
            n_errors++;
            $display("FAIL %s R2 R3 out_valid: actual %b expected %b", st[2], out_valid, sv[2]);
        end
        if (sv[2]) begin
            n_checks++;
            if (out_bit !== sp[2]) begin
                n_errors++;
                $display("FAIL %s R1 out_bit: actual %b expected %b", st[2], out_bit, sp[2]);
            end
        end
        sv[2] = sv[1]; sp[2] = sp[1]; st[2] = st[1];
        sv[1] = sv[0]; sp[1] = sp[0]; st[1] = st[0];
        sv[0] = v;     sp[0] = ref_dot(a, b); st[0] = tag;
        if (!rv) begin
            for (int k = 0; k < 3; k++) sv[k] = 1'b0;
        end
        rst_n    = rv;
        in_valid = v;
        vec_a    = a;
        vec_b    = b;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 3; k++) begin sv[k] = 1'b0; sp[k] = 1'b0; st[k] = "init"; end

        // R5: reset held low; outputs must stay idle.
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, '1, '1, "R5 reset");

        // R6: corner operands.
        step(1'b1, 1'b1, '0, '0, "R6 zeros");
        step(1'b1, 1'b1, '1, '0, "R6 b zero");
        step(1'b1, 1'b1, '0, '1, "R6 a zero");
        step(1'b1, 1'b1, '1, '1, "R6 ones");
        step(1'b1, 1'b1, one_hot(0), one_hot(0), "R6 bit0");
        step(1'b1, 1'b1, one_hot(47), one_hot(47), "R6 bit47");
        step(1'b1, 1'b1, one_hot(95), one_hot(95), "R6 bit95");
        step(1'b1, 1'b1, '1, one_hot(95), "R6 ones x bit95");

        // R7: position pairing.
        step(1'b1, 1'b1, one_hot(5), one_hot(6), "R7 bit5 bit6");
        step(1'b1, 1'b1, one_hot(95), one_hot(0), "R7 bit95 bit0");
        step(1'b1, 1'b1, {48{2'b01}}, {48{2'b10}}, "R7 disjoint");
        step(1'b1, 1'b1, '1, one_hot(2) | one_hot(50) | one_hot(93), "R7 three");
        step(1'b1, 1'b1, {48{2'b01}}, '1, "R7 half");

        // R3: idle cycles with busy data must produce no result.
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, '1, one_hot(i), "R3 idle");

        // R4: long back-to-back burst of random pairs.
        for (int i = 0; i < 200; i++) step(1'b1, 1'b1, rnd_vec(), rnd_vec(), "R4 burst");

        // R1: random pairs with random gaps.
        for (int i = 0; i < 400; i++) begin
            step(1'b1, ($urandom() % 3) != 0, rnd_vec(), rnd_vec(), "R1 random");
        end

        // R5: reset in the middle of a stream drops the pairs in flight.
        step(1'b1, 1'b1, '1, one_hot(3), "R5 pre");
        step(1'b1, 1'b1, '1, one_hot(4), "R5 pre");
        step(1'b0, 1'b1, '1, one_hot(7), "R5 mid");
        step(1'b0, 1'b0, '0, '0, "R5 mid");
        step(1'b1, 1'b1, one_hot(9), one_hot(9), "R5 after");
        step(1'b1, 1'b1, rnd_vec(), rnd_vec(), "R5 after");

        // Drain the pipeline.
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, '0, '0, "drain");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule